// File: doc/BRIEF.md
# Counter-Stepped Phase Delay Strobe

This block re-times a periodic reference strobe by a programmable number of fast step-clock cycles. Every reference pulse starts a countdown, and the block emits one single-cycle output strobe when the countdown finishes. The delay is given in step-clock cycles and is reduced modulo a programmable period count. Delay values from 0 up to one less than the period therefore cover one whole reference period, which is 0 to 360 degrees of phase. The phase in degrees equals delay divided by period, times 360.

New delay and period values are captured on a load strobe and held as a pending setting. A pending setting is adopted only at the next reference strobe. An output pulse that is already counting keeps the timing it started with, and the change of setting can neither add nor remove a pulse. A one-cycle `applied` flag marks the reference strobe at which a pending setting becomes active. A typical use is aligning two acquisition channels: the phase of one channel's strobe is stepped until it lines up with the other.

There are two state machines. The update tracker has states `UPD_NONE` and `UPD_HELD`:
- `UPD_NONE` goes to `UPD_HELD` on an accepted load.
- `UPD_HELD` goes back to `UPD_NONE` on a reference strobe that has no accepted load in the same cycle.
- In every other case the tracker stays where it is.

The delay counter has states `CNT_IDLE` and `CNT_RUN`:
- Any state goes to `CNT_RUN` on a reference strobe with a nonzero effective delay.
- A reference strobe with zero effective delay sends it to `CNT_IDLE`.
- In `CNT_RUN`, the counter returns to `CNT_IDLE` when the count reaches zero. Otherwise it stays in `CNT_RUN` and decrements.

Top module: `pdc_phase_delay`

## Requirements
- R1: After reset, `out_stb` and `applied` are low. The active effective delay is 0, so a reference strobe with no prior load produces `out_stb` in the same cycle.
- R2: With an active effective delay d in 1..P-1, a reference strobe in cycle t gives exactly one `out_stb` pulse, in cycle t+d, and no other pulse.
- R3: With an effective delay of 0, `out_stb` is high in the same cycle as the reference strobe.
- R4: A loaded delay that is equal to or larger than the loaded period wraps modulo the period. For example, delay 16 with period 16 acts as 0, delay 19 with period 16 acts as 3, and delay 255 with period 10 acts as 5.
- R5: A loaded setting takes effect only at the next reference strobe. A pulse already counting when the load arrives still fires at its original delay.
- R6: `applied` is high for exactly the reference-strobe cycle that adopts a pending setting. It stays low on reference strobes when nothing is pending.
- R7: A second load before the next reference strobe replaces the earlier pending setting.
- R8: A load with a period of 0 is ignored. The next reference strobe keeps the previous delay and does not raise `applied`.
- R9: A reference strobe that arrives while a countdown is running restarts the count from the new strobe. The earlier pulse is dropped, so only the pulse d cycles after the newer strobe is emitted.
- R10: A load in the same cycle as a reference strobe does not affect that strobe. It is adopted at the following reference strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_stb | input | 1 | Single-cycle reference event |
| load | input | 1 | Capture `dly_in` and `per_in` as the pending setting |
| dly_in | input | CW | Requested delay in step-clock cycles |
| per_in | input | CW | Reference period in step-clock cycles (0 is rejected) |
| out_stb | output | 1 | Delayed single-cycle strobe |
| applied | output | 1 | High in the cycle a pending setting becomes active |

## Verification
With an effective delay of d, `out_stb` is due exactly d cycles after the cycle of the reference strobe. A delay of 0 gives the pulse in the strobe cycle itself. `applied` belongs to the strobe cycle.

The bench drives each input on the falling edge and samples the outputs 1 ns later, within that same cycle. Each scenario numbers its cycles from the strobe cycle, which is index 0. It records which indices showed a pulse and compares both the index of the first pulse and the total number of pulses against the value worked out from the requirements.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic {
        UPD_NONE,
        UPD_HELD
    } upd_state_t;

    typedef enum logic {
        CNT_IDLE,
        CNT_RUN
    } cnt_state_t;

endpackage

// File: rtl/pdc_wrap.sv
module pdc_wrap #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] dly,
    input  logic [CW-1:0] per,
    output logic          ok,
    output logic [CW-1:0] eff
);
    // A period of zero is not a valid setting.
    always_comb begin
        ok  = (per != '0);
        eff = ok ? (dly % per) : '0;
    end
endmodule

// File: rtl/pdc_settings.sv
module pdc_settings
    import pdc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic          load,
    input  logic [CW-1:0] dly_in,
    input  logic [CW-1:0] per_in,
    output logic [CW-1:0] sel_eff,
    output logic          applied
);
    upd_state_t    upd_q, upd_d;
    logic [CW-1:0] pend_eff, act_eff;
    logic [CW-1:0] wrap_eff;
    logic          per_ok;
    logic          load_ok;

    pdc_wrap #(.CW(CW)) u_wrap (
        .dly (dly_in),
        .per (per_in),
        .ok  (per_ok),
        .eff (wrap_eff)
    );

    assign load_ok = load && per_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= UPD_NONE;
        else        upd_q <= upd_d;
    end

    always_comb begin
        upd_d = upd_q;
        unique case (upd_q)
            UPD_NONE: if (load_ok) upd_d = UPD_HELD;
            UPD_HELD: if (ref_stb && !load_ok) upd_d = UPD_NONE;
            default:  upd_d = UPD_NONE;
        endcase
    end

    // Setting registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_eff <= '0;
            act_eff  <= '0;
        end else begin
            if (ref_stb && upd_q == UPD_HELD) act_eff <= pend_eff;
            if (load_ok) pend_eff <= wrap_eff;
        end
    end

    // Outputs
    always_comb begin
        applied = 1'b0;
        sel_eff = act_eff;
        unique case (upd_q)
            UPD_NONE: ;
            UPD_HELD: begin
                applied = ref_stb;
                sel_eff = pend_eff;
            end
            default: ;
        endcase
    end

    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (pend_eff < $past(per_in)));

    assert_adopt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && upd_q == UPD_HELD) |=> (act_eff == $past(pend_eff)));

    assert_applied_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (applied && !load_ok) |=> (upd_q == UPD_NONE));

    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && per_in == '0 && !ref_stb) |=> (upd_q == $past(upd_q) && $stable(pend_eff)));

endmodule

// File: rtl/pdc_counter.sv
module pdc_counter
    import pdc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic [CW-1:0] eff,
    output logic          out_stb
);
    cnt_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CNT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (ref_stb) begin
            if (eff == '0) begin
                st_d = CNT_IDLE;
            end else begin
                st_d  = CNT_RUN;
                cnt_d = eff - 1'b1;
            end
        end else begin
            unique case (st_q)
                CNT_IDLE: ;
                CNT_RUN: begin
                    if (cnt_q == '0) st_d = CNT_IDLE;
                    else             cnt_d = cnt_q - 1'b1;
                end
                default: st_d = CNT_IDLE;
            endcase
        end
    end

    // Output
    always_comb begin
        out_stb = ref_stb && (eff == '0);
        unique case (st_q)
            CNT_IDLE: ;
            CNT_RUN:  if (cnt_q == '0) out_stb = 1'b1;
            default:  ;
        endcase
    end

    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN && cnt_q != '0 && !ref_stb)
        |=> (st_q == CNT_RUN && cnt_q == $past(cnt_q) - 1'b1));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !ref_stb) |=> (!out_stb || ref_stb));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && eff != '0) |=> (st_q == CNT_RUN && cnt_q == $past(eff) - 1'b1));

endmodule

// File: rtl/pdc_phase_delay.sv
module pdc_phase_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_stb,
    input  logic          load,
    input  logic [CW-1:0] dly_in,
    input  logic [CW-1:0] per_in,
    output logic          out_stb,
    output logic          applied
);
    logic [CW-1:0] sel_eff;

    pdc_settings #(.CW(CW)) u_settings (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .load    (load),
        .dly_in  (dly_in),
        .per_in  (per_in),
        .sel_eff (sel_eff),
        .applied (applied)
    );

    pdc_counter #(.CW(CW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .eff     (sel_eff),
        .out_stb (out_stb)
    );

    assert_zero_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && sel_eff == '0) |-> out_stb);

    assert_one_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_stb && sel_eff == 1) |=> out_stb);

endmodule

// File: tb/tb_pdc_phase_delay.sv
module tb_pdc_phase_delay;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_stb = 1'b0;
    logic          load = 1'b0;
    logic [CW-1:0] dly_in = '0;
    logic [CW-1:0] per_in = '0;
    logic          out_stb;
    logic          applied;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pdc_phase_delay #(.CW(CW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_stb),
        .load    (load),
        .dly_in  (dly_in),
        .per_in  (per_in),
        .out_stb (out_stb),
        .applied (applied)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input int d, input int p);
        @(negedge clk);
        ref_stb = 0; load = 1; dly_in = CW'(d); per_in = CW'(p);
        @(negedge clk);
        load = 0;
    endtask

    // Index 0 is the strobe cycle. A second strobe goes at extra_ref, a load at load_at.
    task automatic measure(input int window, input int extra_ref, input int load_at,
                           input int ld_d, input int ld_p,
                           output int first, output int cnt,
                           output int app0, output int app_tot);
        first = -1; cnt = 0; app0 = 0; app_tot = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            ref_stb = (i == 0) || (i == extra_ref);
            load    = (i == load_at);
            dly_in  = CW'(ld_d);
            per_in  = CW'(ld_p);
            #1;
            if (out_stb) begin
                if (first < 0) first = i;
                cnt++;
            end
            if (applied) begin
                app_tot++;
                if (i == 0) app0 = 1;
            end
        end
        @(negedge clk);
        ref_stb = 0; load = 0;
    endtask

    task automatic simple(input string req, input int exp_idx, input int exp_app);
        int f, c, a0, at;
        measure(20, -1, -1, 0, 0, f, c, a0, at);
        chk({req, " pulse index"}, f, exp_idx);
        chk({req, " pulse count"}, c, 1);
        chk({req, " applied"}, a0, exp_app);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 out_stb at reset", int'(out_stb), 0);
        chk("R1 applied at reset", int'(applied), 0);
        simple("R1", 0, 0);
    endtask

    task automatic t_basic;
        do_load(5, 16);
        simple("R2 first ref d5", 5, 1);
        simple("R6 second ref d5", 5, 0);
        do_load(1, 16);
        simple("R2 d1", 1, 1);
        do_load(15, 16);
        simple("R2 d15", 15, 1);
    endtask

    task automatic t_zero;
        do_load(0, 16);
        simple("R3 d0", 0, 1);
    endtask

    task automatic t_wrap;
        do_load(16, 16);
        simple("R4 16 mod 16", 0, 1);
        do_load(19, 16);
        simple("R4 19 mod 16", 3, 1);
        do_load(255, 10);
        simple("R4 255 mod 10", 5, 1);
    endtask

    task automatic t_inflight;
        int f, c, a0, at;
        do_load(6, 16);
        simple("R5 setup d6", 6, 1);
        measure(20, -1, 2, 2, 16, f, c, a0, at);
        chk("R5 in-flight keeps old delay", f, 6);
        chk("R5 in-flight single pulse", c, 1);
        simple("R5 new delay at next ref", 2, 1);
    endtask

    task automatic t_overwrite;
        do_load(4, 16);
        do_load(7, 16);
        simple("R7 last load wins", 7, 1);
    endtask

    task automatic t_reject;
        do_load(3, 0);
        simple("R8 zero period ignored", 7, 0);
    endtask

    task automatic t_restart;
        int f, c, a0, at;
        measure(20, 3, -1, 0, 0, f, c, a0, at);
        chk("R9 restart pulse index", f, 10);
        chk("R9 restart pulse count", c, 1);
    endtask

    task automatic t_same_cycle;
        int f, c, a0, at;
        measure(20, -1, 0, 1, 16, f, c, a0, at);
        chk("R10 same-cycle load not used", f, 7);
        chk("R10 no applied on that ref", at, 0);
        simple("R10 adopted at following ref", 1, 1);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_zero();
        t_wrap();
        t_inflight();
        t_overwrite();
        t_reject();
        t_restart();
        t_same_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule